// File: doc/BRIEF.md
# Zero-Crossing Period and Phase Meter

This block watches two single-bit zero-crossing comparator outputs. One bit follows the utility line and the other follows the inverter output. Both bits are sampled only on cycles where a tick enable is high, and one tick stands for 50 µs. Near every crossing a comparator output chatters between 0 and 1. A run-length qualifier on each channel removes this chatter, so each true edge is registered once. After an accepted rising edge, a blanking window also locks that channel out.

The meter counts the ticks between consecutive accepted rising crossings of the line signal. A nominal 20 ms line cycle reads 400. It also records how many ticks after the line crossing the inverter crossing arrived. It reports this offset as a signed value folded into half a period. At every accepted line rising crossing the period and the phase are published together with a one-cycle valid strobe. The interval counter saturates at its maximum. While it is saturated, a no-signal flag stays high, and the crossing that ends such an interval produces no measurement. A downstream phase-lock controller uses the outputs to trim the inverter's reference.

Top module: `zc_phase_meter`

## Requirements
- R1: While reset is active, and in the first cycle after it, `meas_valid` is 0, `period_ticks` is 0, `phase_ticks` is 0 and `no_signal` is 1.
- R2: Qualifiers and counters advance only on cycles with `tick_en` high. A waveform of a given length in ticks reads the same period whatever the number of clock cycles between ticks.
- R3: A channel changes its accepted level only after the sampled input differs from that level on HOLD_TICKS (default 3) consecutive ticks. A shorter excursion registers no crossing.
- R4: After an accepted rising crossing, a channel ignores its input for the next BLANK_TICKS (default 100) ticks. A dip in the line signal inside that window creates no extra measurement.
- R5: `period_ticks` equals the number of ticks between the deciding ticks of two consecutive accepted line rising crossings. A 400-tick waveform reads 400.
- R6: The interval counter saturates at 2^CNT_W−1 (1023). `no_signal` is 1 exactly while it is saturated, and the crossing that ends a saturated interval gives no valid strobe. The counter starts saturated, so the first line crossing after reset gives no valid strobe.
- R7: Let L be the number of ticks from the line crossing to the last inverter rising crossing in the same interval. When L is at most half the period, `phase_ticks` = +L, meaning the inverter lags.
- R8: When 2·L exceeds the period, `phase_ticks` = L − period, which is negative and means the inverter leads. When 2·L equals the period exactly, the value is +period/2. `phase_ticks` is two's complement.
- R9: If no inverter rising crossing was accepted within the interval, `phase_ticks` reports 0.
- R10: `meas_valid` is a single-cycle pulse, one clock after the cycle in which the line crossing is accepted. `period_ticks` and `phase_ticks` change only in cycles where `meas_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Sampling tick, one per 50 µs |
| mains_zc | input | 1 | Line comparator output, raw |
| inv_zc | input | 1 | Inverter comparator output, raw |
| period_ticks | output | CNT_W | Last measured line period in ticks |
| phase_ticks | output | CNT_W | Signed inverter-minus-line offset in ticks |
| no_signal | output | 1 | Interval counter saturated |
| meas_valid | output | 1 | One-cycle strobe for a new measurement |

## Verification
The bench feeds both comparators with chatter around every edge, isolated two-tick spikes in mid half-cycle, and a six-tick dip just after the rising edge. A qualifier with the wrong hold length, or with no blanking, would then report short bogus periods. The phase is driven with the inverter lagging, leading, and sitting exactly half a period away. A wrong fold would flip the sign or misplace the boundary. Ticks are also spaced three clocks apart, which exposes a counter that runs on the clock instead of the tick. The bench removes the line signal long enough to saturate the counter and checks that the first crossing on return is suppressed. It also drops the inverter to confirm that a zero phase is reported.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
    localparam int unsigned N_CH          = 2;
    localparam int unsigned CH_LINE       = 0;
    localparam int unsigned CH_INV        = 1;
    localparam int unsigned DEF_CNT_W     = 10;
    localparam int unsigned DEF_HOLD      = 3;
    localparam int unsigned DEF_BLANK     = 100;
endpackage

// File: rtl/zcm_qualifier.sv
// Run-length qualifier with post-rise blanking for one comparator channel.
module zcm_qualifier #(
    parameter int unsigned HOLD_TICKS  = zcm_pkg::DEF_HOLD,
    parameter int unsigned BLANK_TICKS = zcm_pkg::DEF_BLANK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic raw_i,
    output logic rise_o
);
    localparam int unsigned RUN_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam int unsigned BLK_W = $clog2(BLANK_TICKS + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(HOLD_TICKS - 1);
    localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(BLANK_TICKS);

    typedef struct packed {
        logic             level;
        logic [RUN_W-1:0] run;
        logic [BLK_W-1:0] blank;
        logic             rise;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (tick_en) begin
            if (st_q.blank != '0) begin
                st_d.blank = st_q.blank - 1'b1;
                st_d.run   = '0;
            end else if (raw_i != st_q.level) begin
                if (st_q.run == RUN_LAST) begin
                    st_d.level = raw_i;
                    st_d.run   = '0;
                    st_d.rise  = raw_i;
                    if (raw_i) begin
                        st_d.blank = BLK_LOAD;
                    end
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.rise;
endmodule

// File: rtl/zcm_interval.sv
// Tick interval counter, inverter lag capture and signed phase folding.
module zcm_interval #(
    parameter int unsigned CNT_W = zcm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ref_rise_i,
    input  logic             fbk_rise_i,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] phase_o,
    output logic             no_signal_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lag;
        logic             seen;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] phase;
        logic             valid;
    } ivl_st_t;

    ivl_st_t          st_d, st_q;
    logic             eff_seen;
    logic [CNT_W-1:0] eff_lag;
    logic [CNT_W:0]   lag_x2;
    logic [CNT_W-1:0] folded;

    always_comb begin
        eff_seen = st_q.seen | fbk_rise_i;
        eff_lag  = fbk_rise_i ? st_q.cnt : st_q.lag;
        lag_x2   = {eff_lag, 1'b0};
        if (lag_x2 > {1'b0, st_q.cnt}) begin
            folded = eff_lag - st_q.cnt;
        end else begin
            folded = eff_lag;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (ref_rise_i) begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.period = st_q.cnt;
                st_d.phase  = eff_seen ? folded : '0;
                st_d.valid  = 1'b1;
            end
            st_d.cnt  = tick_en ? CNT_ONE : '0;
            st_d.lag  = '0;
            st_d.seen = 1'b0;
        end else begin
            if (fbk_rise_i) begin
                st_d.lag  = st_q.cnt;
                st_d.seen = 1'b1;
            end
            if (tick_en && (st_q.cnt != CNT_MAX)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_o    = st_q.period;
    assign phase_o     = st_q.phase;
    assign valid_o     = st_q.valid;
    assign no_signal_o = (st_q.cnt == CNT_MAX);
endmodule

// File: rtl/zc_phase_meter.sv
// Top: two qualified channels feeding one interval and phase meter.
module zc_phase_meter #(
    parameter int unsigned CNT_W       = zcm_pkg::DEF_CNT_W,
    parameter int unsigned HOLD_TICKS  = zcm_pkg::DEF_HOLD,
    parameter int unsigned BLANK_TICKS = zcm_pkg::DEF_BLANK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mains_zc,
    input  logic             inv_zc,
    output logic [CNT_W-1:0] period_ticks,
    output logic [CNT_W-1:0] phase_ticks,
    output logic             no_signal,
    output logic             meas_valid
);
    import zcm_pkg::*;

    logic [N_CH-1:0] raw_bits;
    logic [N_CH-1:0] rise_bits;

    always_comb begin
        raw_bits          = '0;
        raw_bits[CH_LINE] = mains_zc;
        raw_bits[CH_INV]  = inv_zc;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        zcm_qualifier #(
            .HOLD_TICKS (HOLD_TICKS),
            .BLANK_TICKS(BLANK_TICKS)
        ) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_en(tick_en),
            .raw_i  (raw_bits[g]),
            .rise_o (rise_bits[g])
        );
    end

    zcm_interval #(
        .CNT_W(CNT_W)
    ) u_ivl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ref_rise_i (rise_bits[CH_LINE]),
        .fbk_rise_i (rise_bits[CH_INV]),
        .period_o   (period_ticks),
        .phase_o    (phase_ticks),
        .no_signal_o(no_signal),
        .valid_o    (meas_valid)
    );
endmodule

// File: rtl/zc_phase_meter_sva.sv
module zc_phase_meter_sva #(
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned BLANK_TICKS = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] period_ticks,
    input logic [CNT_W-1:0] phase_ticks,
    input logic             no_signal,
    input logic             meas_valid
);
    int ph_i;
    int per_i;

    always_comb begin
        ph_i  = int'($signed(phase_ticks));
        per_i = int'(period_ticks);
    end

    // R10: strobe lasts one cycle
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    // R10: results hold between strobes
    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> ($stable(period_ticks) && $stable(phase_ticks)));

    // R6: a measurement never coincides with a saturated counter
    assert_no_valid_when_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_signal) |-> !meas_valid);

    // R8: phase stays within half a period
    assert_phase_folded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> ((2 * ph_i <= per_i) && (2 * ph_i >= -per_i)));

    // R4: blanking keeps every period longer than the window
    assert_period_beyond_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (per_i > int'(BLANK_TICKS)));
endmodule

bind zc_phase_meter zc_phase_meter_sva #(
    .CNT_W      (CNT_W),
    .BLANK_TICKS(BLANK_TICKS)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_ticks(period_ticks),
    .phase_ticks (phase_ticks),
    .no_signal   (no_signal),
    .meas_valid  (meas_valid)
);

// File: tb/zc_phase_meter_test.sv
`timescale 1ns/1ps
module zc_phase_meter_test;
    localparam int HOLD  = 3;
    localparam int BLANK = 100;
    localparam int MAXC  = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       mains_zc = 1'b0;
    logic       inv_zc = 1'b0;
    logic [9:0] period_ticks;
    logic [9:0] phase_ticks;
    logic       no_signal;
    logic       meas_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    zc_phase_meter uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .mains_zc(mains_zc), .inv_zc(inv_zc),
        .period_ticks(period_ticks), .phase_ticks(phase_ticks),
        .no_signal(no_signal), .meas_valid(meas_valid)
    );

    // stimulus controls
    int tick_div = 1;
    int cyc = 0;
    int mper = 400;
    int mpos = 0;
    int ioff = 30;
    bit m_off = 0, i_off = 0, burst_en = 0, glitch_en = 0;
    string per_tag = "R5";
    string ph_tag  = "R7";

    // reference model state
    int  lvl[2], run[2], blk[2];
    bit  pend[2];
    int  cnt, lag;
    bit  seen;
    int  exp_period, exp_phase;
    bit  exp_valid, exp_nosig;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit wave(int pos, int per);
        int half = per / 2;
        if (burst_en && pos >= 20 && pos < 26) return 1'b0;
        if (glitch_en && (pos == 150 || pos == 151)) return 1'b0;
        if (glitch_en && (pos == 300 || pos == 301)) return 1'b1;
        if (pos < 4) return (pos % 2) == 0;
        if (pos < half) return 1'b1;
        if (pos < half + 4) return (pos % 2) == 1;
        return 1'b0;
    endfunction

    // behavioural reference, stepped on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                lvl[c] = 0; run[c] = 0; blk[c] = 0; pend[c] = 0;
            end
            cnt = MAXC; lag = 0; seen = 0;
            exp_period = 0; exp_phase = 0; exp_valid = 0; exp_nosig = 1;
        end else begin
            bit mr, ir, rw;
            int el;
            mr = pend[0];
            ir = pend[1];
            exp_valid = 0;
            if (mr) begin
                if (cnt != MAXC) begin
                    exp_period = cnt;
                    if (seen || ir) begin
                        el = ir ? cnt : lag;
                        exp_phase = (2 * el > cnt) ? el - cnt : el;
                    end else begin
                        exp_phase = 0;
                    end
                    exp_valid = 1;
                end
                cnt = tick_en ? 1 : 0;
                seen = 0;
                lag = 0;
            end else begin
                if (ir) begin
                    lag = cnt;
                    seen = 1;
                end
                if (tick_en && cnt < MAXC) cnt++;
            end
            exp_nosig = (cnt == MAXC);
            for (int c = 0; c < 2; c++) begin
                pend[c] = 0;
                rw = (c == 0) ? mains_zc : inv_zc;
                if (tick_en) begin
                    if (blk[c] > 0) begin
                        blk[c]--;
                        run[c] = 0;
                    end else if (int'(rw) != lvl[c]) begin
                        run[c]++;
                        if (run[c] >= HOLD) begin
                            lvl[c] = int'(rw);
                            run[c] = 0;
                            if (rw) begin
                                pend[c] = 1;
                                blk[c] = BLANK;
                            end
                        end
                    end else begin
                        run[c] = 0;
                    end
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(meas_valid == exp_valid, "R10", "meas_valid", int'(meas_valid), int'(exp_valid));
            check(no_signal == exp_nosig, "R6", "no_signal", int'(no_signal), int'(exp_nosig));
            check(int'(period_ticks) == exp_period, per_tag, "period_ticks", int'(period_ticks), exp_period);
            check(int'($signed(phase_ticks)) == exp_phase, ph_tag, "phase_ticks",
                  int'($signed(phase_ticks)), exp_phase);
        end
    end

    task automatic run_cycles(int n);
        for (int k = 0; k < n; k++) begin
            int ipos;
            @(negedge clk);
            tick_en = ((cyc % tick_div) == 0);
            cyc++;
            if (tick_en) begin
                mpos = (mpos + 1) % mper;
                ipos = (mpos - ioff + mper) % mper;
                mains_zc = m_off ? 1'b0 : wave(mpos, mper);
                inv_zc   = i_off ? 1'b0 : wave(ipos, mper);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check(meas_valid == 1'b0, "R1", "reset meas_valid", int'(meas_valid), 0);
        check(period_ticks == '0, "R1", "reset period_ticks", int'(period_ticks), 0);
        check(phase_ticks == '0, "R1", "reset phase_ticks", int'(phase_ticks), 0);
        check(no_signal == 1'b1, "R1", "reset no_signal", int'(no_signal), 1);
        rst_n = 1'b1;

        // R5 / R7: nominal 400-tick line, inverter lags 30
        per_tag = "R5"; ph_tag = "R7";
        mper = 400; ioff = 30; tick_div = 1; mpos = 0;
        run_cycles(2600);
        check(int'(period_ticks) == 400, "R5", "nominal period", int'(period_ticks), 400);
        check(int'($signed(phase_ticks)) == 30, "R7", "lag phase", int'($signed(phase_ticks)), 30);

        // R8: inverter leads by 40
        ph_tag = "R8"; ioff = 360;
        run_cycles(2400);
        check(int'($signed(phase_ticks)) == -40, "R8", "lead phase", int'($signed(phase_ticks)), -40);

        // R2 / R8: sparse ticks, 380-tick period, exact half-period offset
        per_tag = "R2"; ph_tag = "R8";
        tick_div = 3; mper = 380; mpos = 0; ioff = 190;
        run_cycles(380 * 3 * 5);
        check(int'(period_ticks) == 380, "R2", "sparse-tick period", int'(period_ticks), 380);
        check(int'($signed(phase_ticks)) == 190, "R8", "half-period phase", int'($signed(phase_ticks)), 190);

        // R4: dip right after the rising edge is blanked
        per_tag = "R4"; ph_tag = "R4";
        tick_div = 1; mper = 400; mpos = 0; ioff = 50; burst_en = 1;
        run_cycles(2400);
        check(int'(period_ticks) == 400, "R4", "period under dip", int'(period_ticks), 400);
        burst_en = 0;

        // R3: short spikes in mid half-cycle create no crossing
        per_tag = "R3"; ph_tag = "R3";
        glitch_en = 1; ioff = 70;
        run_cycles(2400);
        check(int'(period_ticks) == 400, "R3", "period under spikes", int'(period_ticks), 400);
        check(int'($signed(phase_ticks)) == 70, "R3", "phase under spikes", int'($signed(phase_ticks)), 70);
        glitch_en = 0;

        // R9: inverter absent
        per_tag = "R9"; ph_tag = "R9";
        i_off = 1;
        run_cycles(2000);
        check(int'($signed(phase_ticks)) == 0, "R9", "phase without inverter", int'($signed(phase_ticks)), 0);
        i_off = 0;

        // R6: line lost long enough to saturate, then restored
        per_tag = "R6"; ph_tag = "R6";
        m_off = 1;
        run_cycles(1500);
        check(no_signal == 1'b1, "R6", "no_signal after loss", int'(no_signal), 1);
        m_off = 0; mpos = 0;
        run_cycles(2600);
        check(no_signal == 1'b0, "R6", "no_signal after return", int'(no_signal), 0);
        check(int'(period_ticks) == 400, "R6", "period after return", int'(period_ticks), 400);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule